// File: doc/BRIEF.md
# Nine-Bit Capable UART Framer

This block turns parallel words into asynchronous serial frames and back. Each frame has a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional extra bit, then a high stop bit. The extra bit is not parity. The block sends whatever value the host supplies and hands back whatever bit it receives. This lets a multidrop network use the extra bit as an address/data marker. A 4-bit divisor select sets the bit rate. The receiver oversamples the line at 16 times the bit rate.

Configuration is loaded in parallel with a one-cycle write strobe. The load takes the divisor select, the word-length control and the extra-bit enable. All three reset to zero, which gives 8 data bits, no extra bit and the fastest rate.

The transmit side is a valid/ready sink. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low for the whole frame, and `tx_valid` has no effect while `tx_ready` is low.

The receive side is a valid/ready source. A received word stays on `rx_data`, `rx_xbit` and `rx_ferr` while `rx_valid` is high and `rx_ready` is low. A word that finishes while an earlier word is still waiting is discarded. A word that finishes in the same cycle as an accept takes over the output.

Top module: `uart9_framer`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high and `rx_valid` is low. The configuration is zero: 8 data bits, no extra bit, divisor select 0.
- R2: A transmitted frame is a low start bit, the data bits LSB first and a high stop bit, each bit 16 oversample ticks long. `txd` is high whenever `tx_ready` is high.
- R3: With the word-length control at 1, frames carry 7 data bits. Transmit bit 7 is ignored, and received `rx_data[7]` is 0.
- R4: With the extra-bit enable at 1, the extra bit goes on the line right after the last data bit with exactly the value given on `tx_xbit`. On receive it appears on `rx_xbit` unchanged. No parity is computed.
- R5: With the extra-bit enable at 0, no extra bit is sent and `rx_xbit` reads 0.
- R6: With divisor select `s` and prescale 1, one oversample tick occurs every `s+1` clocks, so one bit lasts `16*(s+1)` clocks.
- R7: If the line is low at the centre of the stop bit, the word is delivered with `rx_ferr` = 1; otherwise `rx_ferr` = 0.
- R8: `tx_ready` goes low only after an accepted handshake and stays low for the whole frame. `tx_valid` is ignored while `tx_ready` is low.
- R9: While `rx_valid` is high and `rx_ready` is low, the receive outputs hold steady. A word that completes in that state is dropped.
- R10: A low pulse on `rxd` that has ended by the mid-bit check of the start bit does not produce a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Loads the three configuration fields below |
| cfg_div_sel | input | 4 | Divisor select |
| cfg_seven | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_xen | input | 1 | 1 = append and expect the extra bit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter idle, word can be taken |
| tx_data | input | 8 | Transmit data |
| tx_xbit | input | 1 | Transmit extra bit |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 8 | Received data |
| rx_xbit | output | 1 | Received extra bit |
| rx_ferr | output | 1 | Stop bit was low for this word |

## Verification
With divisor select 0, `txd` falls in the first cycle after the transmit handshake edge. Each bit then lasts exactly 16 clocks. The bench therefore samples bit `i` at the falling clock edge 8+16·i cycles after the handshake, which is the centre of that bit. A received word appears two synchronizer cycles plus 8+16·(bits) ticks after the start edge. The bench therefore waits on `rx_valid` within a bounded window instead of at a fixed cycle. Bit width at a slower divisor is checked by counting clocks between line transitions. Rejection and drop cases are checked by watching `rx_valid` and `rx_data` over a window longer than a full frame.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int OSR      = 16;
  localparam int MAX_BITS = 11;   // start + 8 + extra + stop
  localparam int BIT_CW   = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_st_t;

  function automatic logic [BIT_CW-1:0] data_bits(input logic seven);
    return seven ? BIT_CW'(7) : BIT_CW'(8);
  endfunction
endpackage

// File: rtl/uart9_cfg.sv
module uart9_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] div_sel_in,
  input  logic       seven_in,
  input  logic       xen_in,
  output logic [3:0] div_sel,
  output logic       seven,
  output logic       xen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= '0;
      seven   <= 1'b0;
      xen     <= 1'b0;
    end else if (we) begin
      div_sel <= div_sel_in;
      seven   <= seven_in;
      xen     <= xen_in;
    end
  end
endmodule

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int PRESCALE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sel,
  output logic       tick
);
  localparam int CW = $clog2(16 * PRESCALE + 1);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = CW'((int'(sel) + 1) * PRESCALE - 1);
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       seven,
  input  logic       xen,
  input  logic       valid,
  output logic       ready,
  input  logic [7:0] data,
  input  logic       xbit,
  output logic       txd
);
  logic                    busy;
  logic [MAX_BITS-2:0]     sh;
  logic [BIT_CW-1:0]       left;
  logic [3:0]              sub;
  logic [MAX_BITS-1:0]     frame;
  logic [BIT_CW-1:0]       nbits;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(data_bits(seven))) frame[1+i] = data[i];
    if (xen) frame[1 + int'(data_bits(seven))] = xbit;
    nbits = data_bits(seven) + BIT_CW'(2) + BIT_CW'(xen);
  end

  assign ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      sub  <= '0;
      txd  <= 1'b1;
    end else if (!busy) begin
      if (valid) begin
        busy <= 1'b1;
        txd  <= 1'b0;
        sh   <= frame[MAX_BITS-1:1];
        left <= nbits - 1'b1;
        sub  <= '0;
      end
    end else if (tick) begin
      sub <= sub + 1'b1;
      if (sub == 4'(OSR - 1)) begin
        if (left == '0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[MAX_BITS-2:1]};
          left <= left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       seven,
  input  logic       xen,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] word,
  output logic       xbit,
  output logic       ferr
);
  rx_st_t            st;
  logic [1:0]        sync;
  logic              line;
  logic [3:0]        sub;
  logic [BIT_CW-1:0] idx;
  logic [8:0]        buf_q;
  logic [BIT_CW-1:0] nrx;

  assign line = sync[1];
  assign nrx  = data_bits(seven) + BIT_CW'(xen);

  always_comb begin
    word = buf_q[7:0];
    if (seven) word[7] = 1'b0;
    xbit = xen ? buf_q[data_bits(seven)] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= 2'b11;
      st    <= RX_IDLE;
      sub   <= '0;
      idx   <= '0;
      buf_q <= '0;
      done  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (!line) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: begin
            sub <= sub + 1'b1;
            if (sub == 4'(OSR/2 - 1)) begin
              sub   <= '0;
              idx   <= '0;
              buf_q <= '0;
              st    <= line ? RX_IDLE : RX_BITS;
            end
          end
          RX_BITS: begin
            sub <= sub + 1'b1;
            if (sub == 4'(OSR - 1)) begin
              buf_q[idx] <= line;
              idx        <= idx + 1'b1;
              if (idx == nrx - 1'b1) st <= RX_STOP;
            end
          end
          RX_STOP: begin
            sub <= sub + 1'b1;
            if (sub == 4'(OSR - 1)) begin
              ferr <= !line;
              done <= 1'b1;
              st   <= RX_IDLE;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart9_framer.sv
module uart9_framer #(
  parameter int PRESCALE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_div_sel,
  input  logic       cfg_seven,
  input  logic       cfg_xen,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_xbit,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_xbit,
  output logic       rx_ferr
);
  logic [3:0] div_q;
  logic       seven_q;
  logic       xen_q;
  logic       tick;
  logic       rdone;
  logic [7:0] rword;
  logic       rxb;
  logic       rfe;

  uart9_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .div_sel_in(cfg_div_sel), .seven_in(cfg_seven), .xen_in(cfg_xen),
    .div_sel(div_q), .seven(seven_q), .xen(xen_q)
  );

  uart9_baud #(.PRESCALE(PRESCALE)) u_baud (
    .clk(clk), .rst_n(rst_n), .sel(div_q), .tick(tick)
  );

  uart9_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .seven(seven_q), .xen(xen_q),
    .valid(tx_valid), .ready(tx_ready), .data(tx_data), .xbit(tx_xbit),
    .txd(txd)
  );

  uart9_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .seven(seven_q), .xen(xen_q),
    .rxd(rxd), .done(rdone), .word(rword), .xbit(rxb), .ferr(rfe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_xbit  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (rdone && (!rx_valid || rx_ready)) begin
        rx_valid <= 1'b1;
        rx_data  <= rword;
        rx_xbit  <= rxb;
        rx_ferr  <= rfe;
      end
    end
  end
endmodule

// File: rtl/uart9_chk.sv
module uart9_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_xbit,
  input logic       rx_ferr,
  input logic       seven_q,
  input logic       xen_q
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);  // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid));  // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_xbit) && $stable(rx_ferr)));  // R9
  AST_SEVEN_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_valid) && seven_q) |-> !rx_data[7]);  // R3
  AST_XBIT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_valid) && !xen_q) |-> !rx_xbit);  // R5
endmodule

bind uart9_framer uart9_chk u_chk (.*);

// File: tb/uart9_framer_tb.sv
module uart9_framer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_seven = 0, cfg_xen = 0;
  logic [3:0] cfg_div_sel = 0;
  logic tx_valid = 0, tx_xbit = 0, rx_ready = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, txd, rx_valid, rx_xbit, rx_ferr;
  logic [7:0] rx_data;
  logic loop = 1'b1, rxd_drv = 1'b1;
  logic rxd;
  int errs = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;
  assign rxd = loop ? txd : rxd_drv;

  uart9_framer u_dut (.*);

  // [19] seven [18] xen [17:10] data [9] xbit [8:1] expected data [0] expected extra
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5, 1'b1, 8'hA5, 1'b0},
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
    {1'b0, 1'b1, 8'h5A, 1'b1, 8'h5A, 1'b1},
    {1'b0, 1'b1, 8'hFF, 1'b0, 8'hFF, 1'b0},
    {1'b1, 1'b0, 8'hC3, 1'b0, 8'h43, 1'b0},
    {1'b1, 1'b1, 8'h80, 1'b1, 8'h00, 1'b1}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errs = errs + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic config_set(input logic [3:0] s, input logic sv, input logic xe);
    @(negedge clk);
    cfg_we = 1; cfg_div_sel = s; cfg_seven = sv; cfg_xen = xe;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic xb);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = d; tx_xbit = xb;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_rx(output bit got);
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (rx_valid) got = 1;
    end
  endtask

  task automatic take();
    rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask

  task automatic drive_bits(input logic [10:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      rxd_drv = bits[i];
      repeat (16) @(negedge clk);
    end
    rxd_drv = 1'b1;
  endtask

  initial begin
    bit got;
    logic [7:0] first;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd idle", txd, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);

    // R1: default configuration is 8 data bits, no extra bit
    send(8'h3C, 1'b1);
    wait_rx(got);
    chk("R1 default word", {got, rx_data, rx_xbit}, {1'b1, 8'h3C, 1'b0});
    take();

    // Table walk: R3 R4 R5 via loopback
    foreach (VEC[k]) begin
      config_set(4'd0, VEC[k][19], VEC[k][18]);
      send(VEC[k][17:10], VEC[k][9]);
      wait_rx(got);
      chk($sformatf("R3/R4/R5 vec%0d word", k), {got, rx_data, rx_xbit},
          {1'b1, VEC[k][8:1], VEC[k][0]});
      chk($sformatf("R7 vec%0d ferr clear", k), rx_ferr, 0);
      take();
    end

    // R2 R4 R8: waveform of 0xA5 with extra bit 1, 8-bit mode
    config_set(4'd0, 1'b0, 1'b1);
    @(negedge clk);
    tx_valid = 1; tx_data = 8'hA5; tx_xbit = 1;
    @(negedge clk);
    tx_valid = 1; tx_data = 8'h00;  // offered while busy: must be ignored
    chk("R8 busy", tx_ready, 0);
    repeat (7) @(negedge clk);
    begin
      logic [10:0] expw;
      expw = {1'b1, 1'b1, 8'hA5, 1'b0};
      for (int i = 0; i < 11; i++) begin
        chk($sformatf("R2/R4 bit%0d", i), txd, expw[i]);
        if (i < 10) repeat (16) @(negedge clk);
      end
    end
    tx_valid = 0;
    wait_rx(got);
    chk("R8 first word kept", {got, rx_data, rx_xbit}, {1'b1, 8'hA5, 1'b1});
    take();
    repeat (200) @(negedge clk);
    chk("R8 no second frame", rx_valid, 0);

    // R6: divisor select 1 -> 32-clock bits
    config_set(4'd1, 1'b0, 1'b0);
    send(8'h01, 1'b0);
    while (txd) @(negedge clk);
    while (!txd) @(negedge clk);
    w = 0;
    while (txd) begin w++; @(negedge clk); end
    chk("R6 bit width", w, 32);
    wait_rx(got);
    chk("R6 word", {got, rx_data}, {1'b1, 8'h01});
    take();

    // R7: framing error, stop bit low
    config_set(4'd0, 1'b0, 1'b0);
    loop = 0;
    drive_bits({1'b0, 8'h96, 1'b0}, 10);
    wait_rx(got);
    chk("R7 ferr word", {got, rx_data, rx_ferr}, {1'b1, 8'h96, 1'b1});
    take();
    repeat (40) @(negedge clk);

    // R10: short start glitch
    rxd_drv = 0; repeat (4) @(negedge clk); rxd_drv = 1;
    repeat (300) @(negedge clk);
    chk("R10 glitch rejected", rx_valid, 0);

    // R9: hold and drop under back-pressure
    loop = 1;
    send(8'h11, 1'b0);
    send(8'h22, 1'b0);
    repeat (250) @(negedge clk);
    first = rx_data;
    chk("R9 held word", {rx_valid, first}, {1'b1, 8'h11});
    take();
    repeat (250) @(negedge clk);
    chk("R9 second dropped", rx_valid, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule